// File: doc/BRIEF.md
# Power-of-Two Reference Clock Divider

This block derives an output clock from a reference clock. The division ratio is a power of two and is chosen by a 3-bit exponent code held in a small register file. The register file has a synchronous write port and a combinational read port. Software sets a factor code, then sets an output-enable bit. A busy status bit stays set until the start or stop has finished. Codes 0 and 1 both pass the reference clock through undivided. Code `f` in 2..7 divides by `2^(f-1)`, which gives an output high for half the period and low for the other half. Starting and stopping are glitch-free: the output changes only at the end of a complete low or high phase, and each transition finishes within a bound that scales with the ratio.

The sequencer is a four-state machine: `ST_OFF`, `ST_WAKE`, `ST_RUN` and `ST_HALT`. Its transitions are:
- `ST_OFF` to `ST_WAKE` when the enable bit is seen set. This loads a settle timer with 3×ratio.
- `ST_WAKE` to `ST_RUN` when the timer reaches zero.
- `ST_RUN` to `ST_HALT` when the enable bit is seen clear. This loads the timer with 3×ratio−2.
- `ST_HALT` to `ST_OFF` when the timer reaches zero and the divider core reports it has parked low.

Each state holds in every other case.

A factor written while the output runs is held by the core until the next rising edge of the output at the old ratio. From that edge on, the new ratio applies.

Top module: `pwr2_clkdiv`

## Requirements
- R1: After reset, both registers read 0, `busy` is 0 and `clk_out` is low.
- R2: The factor register at address 0x43 keeps only write-data bits [2:0]. Reads return them in bits [2:0], with bits [7:3] as 0.
- R3: The control register at address 0x46 reads back the last written enable in bit 7. Bit 0 reads 1 while a start or stop is in progress, and equals `busy`. Every other bit reads 0, and unmapped addresses read 0.
- R4: For factor codes 2 to 7, the running output is high for 2^(f-2) reference cycles and low for 2^(f-2) reference cycles.
- R5: For factor codes 0 and 1, the running output follows the reference clock: high while it is high, low while it is low.
- R6: After enable is written to 1, `busy` is set and clears no later than 2+3×ratio reference cycles after the write edge, and the output runs at the selected ratio.
- R7: After enable is written to 0, `busy` clears no later than 3×ratio reference cycles after the write edge, and `clk_out` then stays low.
- R8: Stopping never shortens a high phase: every high phase of a divided output lasts exactly half the ratio.
- R9: A factor written while the output is stopped takes effect on the next enable.
- R10: A factor written while the output runs takes effect at the next rising edge of the output at the old ratio, and the output continues from that edge at the new ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Register address |
| we | input | 1 | Write strobe, sampled on the rising edge of `clk` |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| clk_out | output | 1 | Divided output clock |
| busy | output | 1 | A start or stop is in progress |

## Verification
The bench targets four corner cases.

- **Undivided pass-through.** Codes 0 and 1 need a gated reference clock. A design that treated code 0 as a divide-by-two would read low when sampled in the high phase.
- **Settle windows.** The bench counts busy cycles against 2+3×ratio and 3×ratio at the smallest and largest ratios. An off-by-one in the timer loads would overrun the bound, and an early stop would leave the output toggling after busy drops.
- **Disable mid-high.** The bench issues a disable one cycle into a high phase and requires the full high phase. A core that parks at once would cut that pulse short.
- **Factor change while running.** After a change while running, the bench expects the first new high and low phases to already have the new length. A design that applied the new code mid-period, or only after re-enable, would show a stretched or old-length phase.

// File: rtl/pwr2_clkdiv_pkg.sv
package pwr2_clkdiv_pkg;

    localparam int FAC_W     = 3;
    localparam int CNT_W     = (1 << FAC_W) - 2;
    localparam int MAX_RATIO = 1 << (CNT_W);
    localparam int TMR_W     = $clog2(3 * MAX_RATIO + 3);

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WAKE,
        ST_RUN,
        ST_HALT
    } seq_state_e;

    // factor code -> exponent of the ratio; codes 0 and 1 both mean ratio 1
    function automatic logic [FAC_W-1:0] fac_to_exp(input logic [FAC_W-1:0] fac);
        return (fac == '0) ? '0 : fac - FAC_W'(1);
    endfunction

    // one-hot mask of the counter bit that forms the output at exponent k
    function automatic logic [CNT_W-1:0] half_mask(input logic [FAC_W-1:0] k);
        return (k == '0) ? '0 : (CNT_W'(1) << (k - FAC_W'(1)));
    endfunction

endpackage

// File: rtl/pwr2_clkdiv_regs.sv
module pwr2_clkdiv_regs
    import pwr2_clkdiv_pkg::*;
#(
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [AW-1:0] FAC_ADDR = 8'h43,
    parameter logic [AW-1:0] EN_ADDR  = 8'h46,
    parameter int          EN_BIT   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             we,
    input  logic [DW-1:0]    wdata,
    input  logic             busy,
    output logic [DW-1:0]    rdata,
    output logic [FAC_W-1:0] fac_q,
    output logic             en_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fac_q <= '0;
            en_q  <= 1'b0;
        end else if (we) begin
            if (addr == FAC_ADDR) fac_q <= wdata[FAC_W-1:0];
            if (addr == EN_ADDR)  en_q  <= wdata[EN_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == FAC_ADDR) begin
            rdata[FAC_W-1:0] = fac_q;
        end else if (addr == EN_ADDR) begin
            rdata[EN_BIT] = en_q;
            rdata[0]      = busy;
        end
    end

    p_fac_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == FAC_ADDR) |=> (fac_q == $past(wdata[FAC_W-1:0])));

    p_en_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == EN_ADDR) |=> (en_q == $past(wdata[EN_BIT])));

endmodule

// File: rtl/pwr2_clkdiv_seq.sv
module pwr2_clkdiv_seq
    import pwr2_clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic [FAC_W-1:0] exp_act,
    input  logic             div_active,
    output logic             run_req,
    output logic             busy
);

    seq_state_e        state, state_nx;
    logic [TMR_W-1:0]  tmr;
    logic [TMR_W-1:0]  ratio;
    logic              tmr_zero;

    assign ratio    = TMR_W'(1) << exp_act;
    assign tmr_zero = (tmr == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:  if (en_req)                   state_nx = ST_WAKE;
            ST_WAKE: if (tmr_zero)                 state_nx = ST_RUN;
            ST_RUN:  if (!en_req)                  state_nx = ST_HALT;
            ST_HALT: if (tmr_zero && !div_active)  state_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            tmr   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_OFF && state_nx == ST_WAKE)
                tmr <= ratio * TMR_W'(3);
            else if (state == ST_RUN && state_nx == ST_HALT)
                tmr <= ratio * TMR_W'(3) - TMR_W'(2);
            else if (!tmr_zero)
                tmr <= tmr - TMR_W'(1);
        end
    end

    always_comb begin
        run_req = 1'b0;
        busy    = 1'b0;
        unique case (state)
            ST_OFF:  busy = en_req;
            ST_WAKE: begin run_req = 1'b1; busy = 1'b1; end
            ST_RUN:  begin run_req = 1'b1; busy = !en_req; end
            ST_HALT: busy = 1'b1;
        endcase
    end

    p_run_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> div_active);

    p_off_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !en_req) |-> !div_active);

endmodule

// File: rtl/pwr2_clkdiv_core.sv
module pwr2_clkdiv_core
    import pwr2_clkdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic [FAC_W-1:0] fac,
    output logic [FAC_W-1:0] exp_act,
    output logic             div_active,
    output logic             clk_out
);

    logic             run_q, out_q, gate_lo;
    logic [CNT_W-1:0] cnt, cnt_nx, hi_len;
    logic [FAC_W-1:0] k_q, k_new;
    logic             bit_nx, rise;

    assign k_new  = fac_to_exp(fac);
    assign cnt_nx = cnt + CNT_W'(1);
    assign bit_nx = |(cnt_nx & half_mask(k_q));
    assign rise   = (k_q == '0) || (bit_nx && !out_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt   <= '0;
            out_q <= 1'b0;
            k_q   <= '0;
        end else if (!run_q) begin
            cnt   <= '0;
            out_q <= 1'b0;
            if (!gate_lo) begin
                k_q   <= k_new;
                run_q <= run_req;
            end
        end else if (!run_req) begin
            // park only where the output is, or is about to be, low
            if (k_q == '0 || !bit_nx) begin
                run_q <= 1'b0;
                cnt   <= '0;
                out_q <= 1'b0;
            end else begin
                cnt   <= cnt_nx;
                out_q <= 1'b1;
            end
        end else if (rise && k_new != k_q) begin
            k_q   <= k_new;
            cnt   <= half_mask(k_new);
            out_q <= (k_new != '0);
        end else begin
            cnt   <= cnt_nx;
            out_q <= bit_nx;
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_lo <= 1'b0;
        else        gate_lo <= run_q && (k_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hi_len <= '0;
        else if (out_q) hi_len <= hi_len + CNT_W'(1);
        else            hi_len <= '0;
    end

    assign exp_act    = k_q;
    assign div_active = run_q || gate_lo;
    assign clk_out    = (k_q == '0) ? (clk & gate_lo) : out_q;

    p_full_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_q) |-> ($past(hi_len) == half_mask($past(k_q)) - CNT_W'(1)));

    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !gate_lo) |-> !out_q);

endmodule

// File: rtl/pwr2_clkdiv.sv
module pwr2_clkdiv
    import pwr2_clkdiv_pkg::*;
#(
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] FAC_ADDR = 8'h43,
    parameter logic [AW-1:0] EN_ADDR  = 8'h46,
    parameter int            EN_BIT   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          clk_out,
    output logic          busy
);

    logic [FAC_W-1:0] fac_q, exp_act;
    logic             en_q, run_req, div_active;

    pwr2_clkdiv_regs #(
        .AW(AW), .DW(DW), .FAC_ADDR(FAC_ADDR), .EN_ADDR(EN_ADDR), .EN_BIT(EN_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .busy(busy), .rdata(rdata), .fac_q(fac_q), .en_q(en_q)
    );

    pwr2_clkdiv_seq u_seq (
        .clk(clk), .rst_n(rst_n), .en_req(en_q), .exp_act(exp_act),
        .div_active(div_active), .run_req(run_req), .busy(busy)
    );

    pwr2_clkdiv_core u_core (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .fac(fac_q),
        .exp_act(exp_act), .div_active(div_active), .clk_out(clk_out)
    );

endmodule

// File: tb/pwr2_clkdiv_bench.sv
module pwr2_clkdiv_bench;

    localparam logic [7:0] A_FAC = 8'h43;
    localparam logic [7:0] A_EN  = 8'h46;
    localparam int NV = 7;
    // {factor code, expected ratio}
    localparam logic [9:0] VEC [NV] = '{
        {3'd3, 7'd4}, {3'd0, 7'd1}, {3'd2, 7'd2}, {3'd7, 7'd64},
        {3'd1, 7'd1}, {3'd5, 7'd16}, {3'd4, 7'd8}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       we = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       clk_out, busy;
    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    pwr2_clkdiv u_pwr2_clkdiv (
        .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
        .rdata(rdata), .clk_out(clk_out), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic smp();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic count_busy(output int n);
        n = 1;
        for (int i = 0; i < 400; i++) begin
            smp();
            if (!busy) break;
            n++;
        end
    endtask

    task automatic find_rise(input logic start_prev);
        logic prev = start_prev;
        for (int i = 0; i < 300; i++) begin
            smp();
            if (clk_out && !prev) break;
            prev = clk_out;
        end
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 1; lo = 1;
        for (int i = 0; i < 200; i++) begin smp(); if (clk_out) hi++; else break; end
        for (int i = 0; i < 200; i++) begin smp(); if (!clk_out) lo++; else break; end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int n, hi, lo, f, r;
        bit all_ok, stopped;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_FAC, d); chk(d == 8'h00, "R1 factor reg", d, 0);
        rd(A_EN, d);  chk(d == 8'h00, "R1 enable reg", d, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(clk_out == 1'b0, "R1 clk_out", clk_out, 0);
        // R2 upper write bits dropped
        wr(A_FAC, 8'hFD); rd(A_FAC, d); chk(d == 8'h05, "R2 factor mask", d, 5);
        // R3 unmapped address
        rd(8'h44, d); chk(d == 8'h00, "R3 unmapped read", d, 0);

        // table walk: factor changes while stopped (R9)
        for (int v = 0; v < NV; v++) begin
            f = int'(VEC[v][9:7]);
            r = int'(VEC[v][6:0]);
            wr(A_FAC, 8'(f));
            rd(A_FAC, d); chk(int'(d) == f, "R2 factor readback", d, f);
            wr(A_EN, 8'h80);
            #1; chk(rdata == 8'h81, "R3 enable+busy readback", rdata, 8'h81);
            count_busy(n); chk(n <= 3 * r + 2, "R6 start window", n, 3 * r + 2);
            rd(A_EN, d); chk(d == 8'h80, "R3 enable steady", d, 8'h80);
            if (r == 1) begin
                all_ok = 1'b1;
                for (int i = 0; i < 6; i++) begin smp(); if (!clk_out) all_ok = 1'b0; end
                @(negedge clk); #1; if (clk_out) all_ok = 1'b0;
                chk(all_ok, "R5 pass-through R9", all_ok, 1);
            end else begin
                find_rise(clk_out);
                measure(hi, lo);
                chk(hi == r / 2 && lo == r / 2, "R4 half period R9", hi * 100 + lo, (r / 2) * 101);
            end
            wr(A_EN, 8'h00);
            count_busy(n); chk(n <= 3 * r, "R7 stop window", n, 3 * r);
            all_ok = 1'b1;
            for (int i = 0; i < 2 * r + 4; i++) begin smp(); if (clk_out) all_ok = 1'b0; end
            chk(all_ok, "R7 held low", all_ok, 1);
        end

        // R10: change ratio while running, 4 -> 16
        wr(A_FAC, 8'd3); wr(A_EN, 8'h80); count_busy(n);
        find_rise(clk_out);
        wr(A_FAC, 8'd5);
        find_rise(clk_out);
        measure(hi, lo);
        chk(hi == 8 && lo == 8, "R10 new ratio from next rise", hi * 100 + lo, 808);

        // R8: disable one cycle into a high phase
        find_rise(clk_out);
        hi = 1; stopped = 1'b0;
        @(negedge clk); addr = A_EN; wdata = 8'h00; we = 1'b1;
        smp(); if (clk_out) hi++; else stopped = 1'b1;
        @(negedge clk); we = 1'b0;
        for (int i = 0; i < 40 && !stopped; i++) begin
            smp(); if (clk_out) hi++; else stopped = 1'b1;
        end
        chk(hi == 8, "R8 high phase kept whole", hi, 8);
        all_ok = 1'b1;
        for (int i = 0; i < 60; i++) begin smp(); if (clk_out) all_ok = 1'b0; end
        chk(all_ok && !busy, "R7 stopped after mid-high disable", all_ok, 1);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule